// File: doc/BRIEF.md
# Multi-Ratio Clock Divider Bank

This block takes two candidate clocks, passes one of them through a 2:1 source select, and uses that clock to drive a bank of divider channels at the same time. Channel k divides by 2^k. Channel 0 can also be switched to divide by 2. Each channel output is replicated onto a set of identical output bits so that several loads can take the same phase.

A single output enable gates the whole bank. The enable is registered on the falling edge of the selected clock. As a result, the dividers start and stop only while that clock is low, and no shortened pulse reaches the divider chain or the outputs. While the bank is disabled, the outputs sit low and the shared divider count is frozen. When the bank is enabled again, every ratio resumes with the phase it had. An asynchronous master reset clears the count and the enable register. The source select and the channel-0 ratio select are expected to change only while the bank is disabled.

Top module: `clkdiv_bank`

## Requirements
- R1: With `clk_sel` = 0 the bank runs from `clk_a`. With `clk_sel` = 1 it runs from `clk_b`. All timing in the requirements below refers to the selected clock.
- R2: Counting m as the number of rising edges of the selected clock seen while enabled since reset (m ≥ 1), channel k ≥ 1 is high exactly when (m−1) mod 2^k < 2^(k−1). This gives a divide by 2^k with 50% duty. For m = 0 every divided channel is low.
- R3: With `ch0_div2` = 0, enabled channel 0 follows the selected clock (divide by 1). With `ch0_div2` = 1 it matches channel 1 (divide by 2). This select changes only while the bank is disabled.
- R4: Output bit `div_out[COPIES*k + j]` carries channel k, and all COPIES bits of one channel are identical.
- R5: A change on `out_en` takes effect only at the next falling edge of the selected clock.
- R6: While the registered enable is low, every output bit is low and the divider count does not advance. After re-enable, the phase resumes from the frozen count.
- R7: After reset, the first rising edge of the selected clock with the enable captured drives every divided channel (k ≥ 1) high on the same edge.
- R8: While `arst` is high, all outputs are low immediately without any clock edge, and the count and enable register are cleared.
- R9: No output high pulse outside reset is shorter than half a period of the selected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock source 0 |
| clk_b | input | 1 | Clock source 1 |
| clk_sel | input | 1 | Source select (0: clk_a, 1: clk_b) |
| arst | input | 1 | Asynchronous master reset, active high |
| out_en | input | 1 | Shared output enable, registered on falling edge |
| ch0_div2 | input | 1 | Channel 0 ratio select (0: ÷1, 1: ÷2) |
| div_out | output | NUM_CH*COPIES | Replicated channel outputs, channel k at bits COPIES*k .. COPIES*k+COPIES−1 |

## Verification
The bench keeps its own count of enabled rising edges and predicts every output bit in both clock phases. It sweeps long runs across every channel, both clock sources and both channel-0 ratios. It toggles the enable mid-high-phase: a design that acted on the enable at once, rather than at the falling edge, would show the wrong level in the low phase and would cut a pulse short. A design that reset the count on disable, or kept counting while disabled, would break phase continuity after re-enable. A design whose ratios were skewed would fail the check that all channels rise together after reset. A pulse-width monitor catches any runt, and a reset applied mid-run must clear the outputs with no clock edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   // divide ratio of channel idx: 2**idx
   function automatic int unsigned chan_ratio(input int unsigned idx);
      return 32'd1 << idx;
   endfunction

   // count bit that produces a ratio (ratios >= 2 only)
   function automatic int unsigned tap_bit(input int unsigned idx);
      return (idx == 0) ? 0 : idx - 1;
   endfunction
endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel,
   output logic clk_o
);
   assign clk_o = sel ? clk_b : clk_a;
endmodule

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync (
   input  logic clk,
   input  logic arst,
   input  logic en_in,
   output logic en_q
);
   // captured while the clock falls, so gating only moves during the low phase
   always_ff @(negedge clk or posedge arst) begin
      if (arst) en_q <= 1'b0;
      else      en_q <= en_in;
   end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int unsigned CW = 3
) (
   input  logic          clk,
   input  logic          arst,
   input  logic          en,
   output logic [CW-1:0] cnt
);
   // down counter: from zero every bit rises on the first enabled edge
   always_ff @(posedge clk or posedge arst) begin
      if (arst)    cnt <= '0;
      else if (en) cnt <= cnt - 1'b1;
   end

   p_hold_r6: assert property (@(posedge clk) disable iff (arst)
      !en |=> $stable(cnt));

   p_count_r2: assert property (@(posedge clk) disable iff (arst)
      en |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
   parameter int unsigned COPIES     = 2,
   parameter bit          HAS_BYPASS = 1'b0
) (
   input  logic              clk,
   input  logic              en,
   input  logic              tap,
   input  logic              half,
   output logic [COPIES-1:0] q
);
   logic base;

   generate
      if (HAS_BYPASS) begin : g_sel
         // divide-by-1 path is the clock gated by the low-phase enable
         assign base = en & (half ? tap : clk);
      end else begin : g_fix
         logic unused_in;
         assign unused_in = clk ^ half;
         assign base = en & tap;
      end
   endgenerate

   assign q = {COPIES{base}};
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned COPIES = 2
) (
   input  logic                     clk_a,
   input  logic                     clk_b,
   input  logic                     clk_sel,
   input  logic                     arst,
   input  logic                     out_en,
   input  logic                     ch0_div2,
   output logic [NUM_CH*COPIES-1:0] div_out
);
   import clkdiv_pkg::*;

   localparam int unsigned CW = (NUM_CH > 1) ? NUM_CH - 1 : 1;
   localparam int unsigned OW = NUM_CH * COPIES;

   generate
      if (NUM_CH < 2)  begin : g_bad_ch  $error("NUM_CH must be at least 2");  end
      if (COPIES < 1)  begin : g_bad_cp  $error("COPIES must be at least 1");  end
      if (NUM_CH > 16) begin : g_big_ch  $error("NUM_CH above 16 not supported"); end
   endgenerate

   logic          sclk;
   logic          en_q;
   logic [CW-1:0] cnt;
   logic [NUM_CH-1:0] first_copy;

   clkdiv_src_mux u_mux (
      .clk_a (clk_a),
      .clk_b (clk_b),
      .sel   (clk_sel),
      .clk_o (sclk)
   );

   clkdiv_en_sync u_en (
      .clk   (sclk),
      .arst  (arst),
      .en_in (out_en),
      .en_q  (en_q)
   );

   clkdiv_counter #(.CW(CW)) u_cnt (
      .clk  (sclk),
      .arst (arst),
      .en   (en_q),
      .cnt  (cnt)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         localparam int unsigned TB = tap_bit(gi);
         clkdiv_channel #(
            .COPIES     (COPIES),
            .HAS_BYPASS (gi == 0)
         ) u_ch (
            .clk  (sclk),
            .en   (en_q),
            .tap  (cnt[TB]),
            .half (ch0_div2),
            .q    (div_out[gi*COPIES +: COPIES])
         );
         assign first_copy[gi] = div_out[gi*COPIES];
      end
   endgenerate

   // disabled bank drives nothing at a rising edge
   p_quiet_r6: assert property (@(posedge sclk) disable iff (arst)
      !en_q |-> (div_out == {OW{1'b0}}));

   // from a zero count every divided channel rises on the same edge
   p_align_r7: assert property (@(posedge sclk) disable iff (arst)
      (en_q && cnt == '0) |=> (!en_q || (&first_copy[NUM_CH-1:1])));
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
   localparam int NCH = 4;
   localparam int NCP = 2;

   logic clk_a = 1'b0, clk_b = 1'b0;
   logic clk_sel = 1'b0, arst = 1'b1, out_en = 1'b0, ch0_div2 = 1'b0;
   logic [NCH*NCP-1:0] div_out;
   logic sclk;

   int checks = 0, errors = 0;
   int m = 0;
   bit en_m = 1'b0;
   bit mon_on = 1'b0;
   bit done = 1'b0;
   string cur_tag = "R2";

   clkdiv_bank #(.NUM_CH(NCH), .COPIES(NCP)) u_dut (
      .clk_a(clk_a), .clk_b(clk_b), .clk_sel(clk_sel), .arst(arst),
      .out_en(out_en), .ch0_div2(ch0_div2), .div_out(div_out)
   );

   initial forever #10 clk_a = ~clk_a;            // 50 MHz
   initial begin #3; forever #15 clk_b = ~clk_b; end
   assign sclk = clk_sel ? clk_b : clk_a;

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic expv(input int c, input bit hi);
      int r;
      if (!en_m) return 1'b0;
      r = (c == 0) ? (ch0_div2 ? 2 : 1) : (1 << c);
      if (r == 1) return hi;
      if (m == 0) return 1'b0;
      return (((m - 1) % r) < (r / 2));
   endfunction

   task automatic sample(input bit hi);
      for (int c = 0; c < NCH; c++) begin
         chk(cur_tag, div_out[c*NCP], expv(c, hi));
         for (int j = 1; j < NCP; j++)
            chk("R4", div_out[c*NCP+j], div_out[c*NCP]);   // copies agree
      end
   endtask

   // one selected-clock period; enable request changes mid-high phase (R5)
   task automatic step(input logic en_next);
      @(posedge sclk);
      if (en_m) m++;
      #4; sample(1'b1);
      out_en = en_next;
      @(negedge sclk);
      en_m = out_en;
      #4; sample(1'b0);
   endtask

   // pulse-width monitor (R9)
   time rise_t [NCH*NCP];
   logic [NCH*NCP-1:0] prev_o = '0;
   always @(div_out) begin
      for (int b = 0; b < NCH*NCP; b++) begin
         if (div_out[b] === 1'b1 && prev_o[b] !== 1'b1) rise_t[b] = $time;
         if (div_out[b] === 1'b0 && prev_o[b] === 1'b1 && mon_on) begin
            checks++;
            if ($time - rise_t[b] < (clk_sel ? 15 : 10)) begin
               errors++;
               $display("FAIL R9: bit %0d pulse actual %0t expected >= %0d",
                        b, $time - rise_t[b], clk_sel ? 15 : 10);
            end
         end
      end
      prev_o = div_out;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      #45;
      chk("R8", |div_out, 1'b0);
      @(negedge clk_a); arst = 1'b0; mon_on = 1'b1;

      cur_tag = "R6";
      repeat (3) step(1'b0);

      // R5/R7: enable captured at the falling edge, then aligned first edge
      cur_tag = "R5";
      step(1'b1);
      @(posedge sclk); m++; #4;
      for (int c = 1; c < NCH; c++) chk("R7", div_out[c*NCP], 1'b1);
      sample(1'b1);
      @(negedge sclk); #4; sample(1'b0);

      cur_tag = "R2";
      repeat (40) step(1'b1);

      // R6: freeze and resume with the same phase
      cur_tag = "R6";
      step(1'b0);
      repeat (5) step(1'b0);
      step(1'b1);
      repeat (21) step(1'b1);

      // R3: channel 0 divide by 2
      step(1'b0);
      repeat (2) step(1'b0);
      ch0_div2 = 1'b1;
      cur_tag = "R3";
      step(1'b1);
      repeat (20) step(1'b1);
      step(1'b0);
      ch0_div2 = 1'b0;
      repeat (2) step(1'b0);

      // R1: switch to clk_b while disabled
      mon_on = 1'b0;
      clk_sel = 1'b1;
      cur_tag = "R1";
      repeat (3) step(1'b0);
      mon_on = 1'b1;
      step(1'b1);
      repeat (25) step(1'b1);

      // R8: asynchronous reset mid-run, no clock edge before the check
      @(posedge sclk); m++; #4;
      sample(1'b1);
      mon_on = 1'b0;
      arst = 1'b1;
      #1;
      chk("R8", |div_out, 1'b0);
      out_en = 1'b0;
      #40;
      chk("R8", |div_out, 1'b0);
      @(negedge sclk); #4;
      arst = 1'b0; m = 0; en_m = 1'b0;
      mon_on = 1'b1;
      cur_tag = "R8";
      repeat (2) step(1'b0);
      step(1'b1);
      @(posedge sclk); m++; #4;
      for (int c = 1; c < NCH; c++) chk("R7", div_out[c*NCP], 1'b1);
      sample(1'b1);
      @(negedge sclk); #4; sample(1'b0);
      cur_tag = "R2";
      repeat (20) step(1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule